// File: doc/BRIEF.md
# Level-Match GPIO Controller

This block controls a small bank of general-purpose pins through six word registers on a single-cycle register bus. Each pin has two independent selections. The first decides whether the pin belongs to the GPIO logic or to an alternate-function signal. The second decides whether the pin is an input or an output.

Pin inputs pass through a two-flop synchronizer. Both data reads and interrupt detection use the synchronized value, and the same value is handed to the alternate-function side. Interrupts work by level match, not by edge detection:

- A per-pin status bit is set whenever the synchronized pin equals that pin's programmed level.
- The status bit stays set until software writes a 0 to it.
- A per-pin steering register sends each status bit either to the ordinary interrupt output or to the non-maskable interrupt output.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: Register word offsets are as follows. Reads of 0x18 or 0x1C, or of any offset whose two low address bits are non-zero, return 0. Writes to those offsets change nothing.

  | Offset | Register |
  |--------|----------|
  | 0x00 | routing (1 = alternate function) |
  | 0x04 | direction (1 = output) |
  | 0x08 | data |
  | 0x0C | match level |
  | 0x10 | match status |
  | 0x14 | non-maskable steering |

- R2: Only bits 13:0 exist, one per pin. Bits 31:14 always read 0, and writing ones to them has no effect.
- R3: During reset every register reads 0, no pin is driven (pin_oe = 0), and irq and nmi are low.
- R4: For a pin with routing 0, pin_oe equals its direction bit and pin_out equals its data bit.
- R5: For a pin with routing 1, pin_out and pin_oe follow alt_out and alt_oe, whatever the direction and data bits hold.
- R6: A data read and alt_in return the pin value after two clock edges of synchronization. A change driven before edge 1 is not visible after edge 1, and is visible after edge 2.
- R7: A status bit becomes 1 on the edge after the synchronized pin equals its level bit, which is edge 3 counted from the pin change.
- R8: A set status bit stays 1 after the pin stops matching.
- R9: Writing 0 to a status bit clears it and writing 1 leaves it unchanged. If a match is present in the same cycle as the clear, the bit stays 1.
- R10: irq is the OR of the status bits whose steering bit is 0. nmi is the OR of the status bits whose steering bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 14 | Pad input values |
| pin_out | output | 14 | Pad output values |
| pin_oe | output | 14 | Pad output enables |
| alt_out | input | 14 | Alternate-function output values |
| alt_oe | input | 14 | Alternate-function output enables |
| alt_in | output | 14 | Synchronized pin values for the alternate functions |
| irq | output | 1 | Ordinary interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
The bench samples the data register and the status register on each of the three edges after a pin change. A synchronizer one flop short, or status logic that compares the raw pin, would show the change one edge early.

It clears a status bit while its pin still matches. A design that gives the clear priority would drop the bit for a cycle and release irq.

It writes ones to a status bit and to the unused upper bits. A design with write-1-to-clear semantics, or with a full-width register, would lose the bit or read the upper bits back.

It sets the direction bits opposite to the alternate-function enables. A multiplexer that consults the direction bits for routed pins would drive the wrong pads.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
   typedef enum logic [2:0] {
      REG_ROUTE = 3'd0,
      REG_DIR   = 3'd1,
      REG_DATA  = 3'd2,
      REG_LEVEL = 3'd3,
      REG_STAT  = 3'd4,
      REG_STEER = 3'd5
   } reg_idx_e;
   localparam int unsigned NUM_REGS = 6;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
   parameter int unsigned W      = 14,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_lvl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned NPINS = 14,
   parameter int unsigned AW    = 5,
   parameter int unsigned DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wr,
   input  logic [AW-1:0]    addr,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] pin_sync,
   input  logic [NPINS-1:0] stat_q,
   output logic [NPINS-1:0] route_q,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] data_q,
   output logic [NPINS-1:0] level_q,
   output logic [NPINS-1:0] steer_q,
   output logic             stat_wr,
   output logic [DW-1:0]    rdata
);
   localparam int unsigned IDXW = AW - 2;

   generate
      if (AW < 5) begin : g_bad_aw
         $error("gpio_lvl_regs: AW must cover six word registers");
      end
      if (NPINS < 1 || NPINS > DW) begin : g_bad_npins
         $error("gpio_lvl_regs: NPINS must lie in 1..DW");
      end
   endgenerate

   logic [IDXW-1:0] idx;
   logic            aligned;
   logic            mapped;
   logic            wen;

   assign idx     = addr[AW-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign mapped  = aligned && (idx < IDXW'(NUM_REGS));
   assign wen     = sel && wr && mapped;
   assign stat_wr = wen && (idx == IDXW'(REG_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
         dir_q   <= '0;
         data_q  <= '0;
         level_q <= '0;
         steer_q <= '0;
      end else if (wen) begin
         if (idx == IDXW'(REG_ROUTE)) route_q <= wdata;
         if (idx == IDXW'(REG_DIR))   dir_q   <= wdata;
         if (idx == IDXW'(REG_DATA))  data_q  <= wdata;
         if (idx == IDXW'(REG_LEVEL)) level_q <= wdata;
         if (idx == IDXW'(REG_STEER)) steer_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (mapped) begin
         if (idx == IDXW'(REG_ROUTE)) rdata[NPINS-1:0] = route_q;
         if (idx == IDXW'(REG_DIR))   rdata[NPINS-1:0] = dir_q;
         if (idx == IDXW'(REG_DATA))  rdata[NPINS-1:0] = pin_sync;
         if (idx == IDXW'(REG_LEVEL)) rdata[NPINS-1:0] = level_q;
         if (idx == IDXW'(REG_STAT))  rdata[NPINS-1:0] = stat_q;
         if (idx == IDXW'(REG_STEER)) rdata[NPINS-1:0] = steer_q;
      end
   end

   // R1
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !wr && !mapped) |-> (rdata == '0))
      else $error("unmapped read returned non-zero");
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
   parameter int unsigned NPINS = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_sync,
   input  logic [NPINS-1:0] level_q,
   input  logic [NPINS-1:0] steer_q,
   input  logic             stat_wr,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] stat_q,
   output logic             irq,
   output logic             nmi
);
   logic [NPINS-1:0] match;
   logic [NPINS-1:0] clr;

   assign match = ~(pin_sync ^ level_q);
   assign clr   = stat_wr ? ~wdata : '0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr) | match;

   assign irq = |(stat_q & ~steer_q);
   assign nmi = |(stat_q &  steer_q);

   // R7
   match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(match) & ~stat_q) == '0))
      else $error("matching pin left status clear");

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(stat_q) & ~$past(clr) & ~stat_q) == '0))
      else $error("status bit dropped without a clear");

   // R9
   clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((stat_q & ~$past(stat_q) & ~$past(match)) == '0))
      else $error("status bit set without a match");
endmodule

// File: rtl/gpio_lvl_pinmux.sv
module gpio_lvl_pinmux #(
   parameter int unsigned NPINS = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] route_q,
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] data_q,
   input  logic [NPINS-1:0] alt_out,
   input  logic [NPINS-1:0] alt_oe,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe
);
   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      always_comb begin
         if (route_q[p]) begin
            pin_out[p] = alt_out[p];
            pin_oe[p]  = alt_oe[p];
         end else begin
            pin_out[p] = data_q[p];
            pin_oe[p]  = dir_q[p];
         end
      end
   end

   // R4
   gpio_input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~route_q & ~dir_q) == '0)
      else $error("GPIO input pin is driven");

   // R5
   alt_enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_q & (pin_oe ^ alt_oe)) == '0)
      else $error("routed pin enable differs from alternate enable");
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl #(
   parameter int unsigned NPINS       = 14,
   parameter int unsigned AW          = 5,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   input  logic [NPINS-1:0] alt_out,
   input  logic [NPINS-1:0] alt_oe,
   output logic [NPINS-1:0] alt_in,
   output logic             irq,
   output logic             nmi
);
   localparam logic [DW-1:0] PIN_MASK = (NPINS >= DW) ? '1 : ((DW'(1) << NPINS) - DW'(1));

   logic [NPINS-1:0] pin_sync;
   logic [NPINS-1:0] route_q, dir_q, data_q, level_q, steer_q, stat_q;
   logic             stat_wr;
   logic             unused_wdata_hi;

   assign unused_wdata_hi = ^(bus_wdata & ~PIN_MASK);

   gpio_lvl_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync));

   gpio_lvl_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata[NPINS-1:0]), .pin_sync(pin_sync), .stat_q(stat_q),
      .route_q(route_q), .dir_q(dir_q), .data_q(data_q), .level_q(level_q),
      .steer_q(steer_q), .stat_wr(stat_wr), .rdata(bus_rdata));

   gpio_lvl_irq #(.NPINS(NPINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .level_q(level_q),
      .steer_q(steer_q), .stat_wr(stat_wr), .wdata(bus_wdata[NPINS-1:0]),
      .stat_q(stat_q), .irq(irq), .nmi(nmi));

   gpio_lvl_pinmux #(.NPINS(NPINS)) u_mux (
      .clk(clk), .rst_n(rst_n), .route_q(route_q), .dir_q(dir_q),
      .data_q(data_q), .alt_out(alt_out), .alt_oe(alt_oe),
      .pin_out(pin_out), .pin_oe(pin_oe));

   assign alt_in = pin_sync;

   // R2
   rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~PIN_MASK) == '0)
      else $error("unused read bits non-zero");

   // R10
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q == '0) |-> (!irq && !nmi))
      else $error("interrupt raised with empty status");
endmodule

// File: tb/sim_gpio_lvl_ctrl.sv
module sim_gpio_lvl_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] M = 32'h0000_3FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [13:0] pin_in, pin_out, pin_oe, alt_in;
   logic [13:0] alt_out = '0, alt_oe = '0, ext_drv = '0;
   logic        irq, nmi;
   int          n_chk = 0, n_bad = 0;
   logic [31:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_drv);

   gpio_lvl_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in),
      .irq(irq), .nmi(nmi));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         rd(5'(i*4), rv);
         chk("R3 register zero in reset", rv, 32'h0);
      end
      chk("R3 no pin driven", {18'h0, pin_oe}, 32'h0);
      chk("R3 irq/nmi low", {30'h0, irq, nmi}, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      repeat (3) @(negedge clk);
      rd(5'h10, rv);
      chk("R7 all pins match zero level", rv, M);
      chk("R10 irq from unsteered status", {31'h0, irq}, 32'h1);
   endtask

   task automatic t_map();
      wr(5'h00, 32'h0000_2A5A); wr(5'h04, 32'h0000_1234);
      wr(5'h0C, 32'hFFFF_C3C3); wr(5'h14, 32'hFFFF_FFFF);
      rd(5'h00, rv); chk("R1 routing at 0x00", rv, 32'h2A5A);
      rd(5'h04, rv); chk("R1 direction at 0x04", rv, 32'h1234);
      rd(5'h0C, rv); chk("R2 level upper bits dropped", rv, 32'h03C3);
      rd(5'h14, rv); chk("R2 steering upper bits dropped", rv, M);
      wr(5'h18, 32'hFFFF_FFFF); wr(5'h02, 32'h0);
      rd(5'h18, rv); chk("R1 0x18 reads zero", rv, 32'h0);
      rd(5'h1C, rv); chk("R1 0x1C reads zero", rv, 32'h0);
      rd(5'h01, rv); chk("R1 misaligned read zero", rv, 32'h0);
      rd(5'h00, rv); chk("R1 unmapped writes ignored", rv, 32'h2A5A);
      wr(5'h00, 0); wr(5'h04, 0); wr(5'h0C, 0); wr(5'h14, 0);
   endtask

   task automatic t_drive();
      ext_drv = 14'h2B00;
      wr(5'h04, 32'h00FF); wr(5'h08, 32'h3CA5);
      chk("R4 enable follows direction", {18'h0, pin_oe}, 32'h00FF);
      chk("R4 value follows data", {24'h0, pin_out[7:0]}, 32'hA5);
      repeat (3) @(negedge clk);
      rd(5'h08, rv);
      chk("R6 data read shows pin state", rv, 32'h2BA5);
   endtask

   task automatic t_alt();
      alt_out = 14'h2000; alt_oe = 14'h3000;
      wr(5'h00, 32'h3000);
      chk("R5 routed enables from alt", {18'h0, pin_oe}, 32'h30FF);
      chk("R5 routed values from alt", {30'h0, pin_out[13:12]}, 32'h2);
      wr(5'h04, 32'h0); wr(5'h08, 32'h0);
      chk("R5 routed pins ignore direction", {18'h0, pin_oe}, 32'h3000);
      alt_oe = 14'h0000;
      @(negedge clk);
      chk("R5 alt enable release", {18'h0, pin_oe}, 32'h0);
      wr(5'h00, 32'h0);
      alt_out = '0;
   endtask

   task automatic t_sync();
      ext_drv = '0;
      repeat (4) @(negedge clk);
      ext_drv = 14'h0001;
      rd(5'h08, rv);
      chk("R6 not visible after edge 1", rv, 32'h0);
      chk("R6 alt_in not yet after edge 1", {18'h0, alt_in}, 32'h0);
      rd(5'h08, rv);
      chk("R6 visible after edge 2", rv, 32'h1);
      chk("R6 alt_in after edge 2", {18'h0, alt_in}, 32'h1);
      ext_drv = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_sticky();
      wr(5'h0C, M);
      repeat (3) @(negedge clk);
      wr(5'h10, 32'h0);
      rd(5'h10, rv); chk("R9 write zero clears", rv, 32'h0);
      chk("R10 irq low with empty status", {31'h0, irq}, 32'h0);
      ext_drv = 14'h0008;
      rd(5'h10, rv); chk("R7 no set after edge 1", rv, 32'h0);
      rd(5'h10, rv); chk("R7 no set after edge 2", rv, 32'h0);
      rd(5'h10, rv); chk("R7 set after edge 3", rv, 32'h8);
      ext_drv = '0;
      repeat (4) @(negedge clk);
      rd(5'h10, rv); chk("R8 status held after mismatch", rv, 32'h8);
      wr(5'h10, M);
      rd(5'h10, rv); chk("R9 write one keeps bit", rv, 32'h8);
      wr(5'h10, 32'h3FF7);
      rd(5'h10, rv); chk("R9 write zero clears bit", rv, 32'h0);
      ext_drv = 14'h0020;
      repeat (4) @(negedge clk);
      wr(5'h10, 32'h0);
      rd(5'h10, rv); chk("R9 clear loses to live match", rv, 32'h20);
      chk("R9 irq kept during clear", {31'h0, irq}, 32'h1);
   endtask

   task automatic t_irq();
      chk("R10 unsteered to irq", {30'h0, irq, nmi}, 32'h2);
      wr(5'h14, 32'h0020);
      chk("R10 steered to nmi", {30'h0, irq, nmi}, 32'h1);
      wr(5'h14, 32'h0010);
      chk("R10 other steering bit irrelevant", {30'h0, irq, nmi}, 32'h2);
      ext_drv = '0;
      repeat (4) @(negedge clk);
      wr(5'h10, 32'h0);
      chk("R10 both low after clear", {30'h0, irq, nmi}, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_map();
      t_drive();
      t_alt();
      t_sync();
      t_sticky();
      t_irq();
      finish_run();
   end
endmodule